// File: doc/BRIEF.md
# Sequential Integer Multiply Unit

This block multiplies two 32-bit operands over several clock cycles and leaves the product in a pair of dedicated result registers, one high and one low. Four operations are selected by a two-bit code. Two are full-width (signed and unsigned 32 x 32 giving 64 bits). Two are half-width (signed and unsigned 16 x 16 giving 32 bits). Internally it takes operand magnitudes and adds one 8-bit slice of the multiplier into an accumulator per cycle. The sign is applied when the result is written.

A one-cycle start pulse launches an operation. A busy output covers the whole operation, and a one-cycle done pulse marks the cycle in which the new result and flags first appear. The block drives negative, zero and overflow flag values together with per-flag update strobes. Surrounding logic uses the strobes to decide which status bits to overwrite. There is no carry output; the carry flag is never touched.

Top module: `mul_seq_unit`

## Requirements
- R1: Operation code 2'b00 multiplies the two 32-bit operands as signed and 2'b01 as unsigned; the 64-bit product goes with bits [63:32] to the high register and bits [31:0] to the low register.
- R2: Operation code 2'b10 (signed) and 2'b11 (unsigned) multiply bits [15:0] of each operand, sign- or zero-extended, write the 32-bit product to the low register and leave the high register unchanged.
- R3: For a full-width operation accepted at clock edge k, busy is high after edges k through k+4, and done is high with the new result after edge k+5.
- R4: For a half-width operation accepted at edge k, busy is high after edges k through k+2, and done is high with the new result after edge k+3.
- R5: A start pulse while busy is high is ignored; the running operation's result and timing are unaffected and no extra done follows.
- R6: On every done, the negative flag equals bit 31 of the low register and the zero flag is set when the low register is zero; the negative and zero update strobes pulse together with done.
- R7: On a full-width done, the overflow flag is set when the 64-bit product does not fit in 32 bits: as a signed value for code 2'b00, as an unsigned value for code 2'b01. The overflow update strobe pulses with done only for full-width operations.
- R8: A half-width operation leaves the overflow flag unchanged.
- R9: After reset, busy, done, all strobes, both result registers and all flags are zero.
- R10: The result registers and flags hold their values in every cycle that is not a done cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, accepted when not busy |
| op_i | input | 2 | Operation code (see R1, R2) |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| hi_o | output | 32 | High result register |
| lo_o | output | 32 | Low result register |
| flag_n_o | output | 1 | Negative flag value |
| flag_z_o | output | 1 | Zero flag value |
| flag_v_o | output | 1 | Overflow flag value |
| upd_n_o | output | 1 | Negative flag update strobe |
| upd_z_o | output | 1 | Zero flag update strobe |
| upd_v_o | output | 1 | Overflow flag update strobe |

## Verification
The bench drives the most negative value, -1, 0 and 1 into every operation code. A design that negates magnitudes wrongly would return a positive product for -2^31 x 1, and one that forgets the 16-bit sign extension would get 0xFFFF x 0xFFFF wrong for code 2'b10. The signed overflow boundary is probed with -2^31 x -1, where the product +2^31 fits the unsigned test but not the signed one. Half-width operations follow full-width ones with a non-zero high word, so a design that clears the high register or the overflow flag shows up. Start pulses injected during busy expose a design that restarts, changes its result or emits a second done.

// File: rtl/mul_pkg.sv
`timescale 1ns/1ps
package mul_pkg;

  typedef enum logic [1:0] {
    OP_SFULL = 2'b00,
    OP_UFULL = 2'b01,
    OP_SHALF = 2'b10,
    OP_UHALF = 2'b11
  } mul_op_e;

  function automatic logic op_is_half(input logic [1:0] op);
    return op[1];
  endfunction

  function automatic logic op_is_signed(input logic [1:0] op);
    return ~op[0];
  endfunction

endpackage

// File: rtl/mul_operand_prep.sv
`timescale 1ns/1ps
module mul_operand_prep
  import mul_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = 16
) (
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] mag_a_o,
  output logic [DATA_W-1:0] mag_b_o,
  output logic              neg_o
);

  localparam int unsigned PAD_W = DATA_W - HALF_W;

  function automatic logic [DATA_W-1:0] widen(
    input logic [DATA_W-1:0] v, input logic half, input logic sgn);
    if (!half) return v;
    if (sgn)   return {{PAD_W{v[HALF_W-1]}}, v[HALF_W-1:0]};
    return {{PAD_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] magnitude(
    input logic [DATA_W-1:0] v, input logic sgn);
    if (sgn && v[DATA_W-1]) return ~v + 1'b1;
    return v;
  endfunction

  logic              half_w;
  logic              sgn_w;
  logic [DATA_W-1:0] ext_a;
  logic [DATA_W-1:0] ext_b;

  always_comb begin
    half_w  = op_is_half(op_i);
    sgn_w   = op_is_signed(op_i);
    ext_a   = widen(a_i, half_w, sgn_w);
    ext_b   = widen(b_i, half_w, sgn_w);
    mag_a_o = magnitude(ext_a, sgn_w);
    mag_b_o = magnitude(ext_b, sgn_w);
    neg_o   = sgn_w & (ext_a[DATA_W-1] ^ ext_b[DATA_W-1]);
  end

endmodule

// File: rtl/mul_ctrl.sv
`timescale 1ns/1ps
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned HALF_W  = 16,
  parameter int unsigned CHUNK_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] op_i,
  input  logic       neg_i,
  output logic       load_o,
  output logic       step_o,
  output logic       fin_o,
  output logic       busy_o,
  output logic [1:0] op_q_o,
  output logic       neg_q_o
);

  localparam int unsigned LAT_FULL = DATA_W / CHUNK_W + 1;
  localparam int unsigned LAT_HALF = HALF_W / CHUNK_W + 1;
  localparam int unsigned CNT_W    = $clog2(LAT_FULL);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       op_q;
  logic             neg_q;

  function automatic logic [CNT_W-1:0] first_count(input logic [1:0] op);
    if (op_is_half(op)) return CNT_W'(LAT_HALF - 1);
    return CNT_W'(LAT_FULL - 1);
  endfunction

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q & (cnt_q != '0);
  assign fin_o  = busy_q & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_SFULL;
      neg_q  <= 1'b0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      cnt_q  <= first_count(op_i);
      op_q   <= op_i;
      neg_q  <= neg_i;
    end else if (fin_o) begin
      busy_q <= 1'b0;
    end else if (step_o) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign op_q_o  = op_q;
  assign neg_q_o = neg_q;

  assert_busy_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !busy_o);
  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !fin_o) |=> (busy_o && $stable(op_q_o) && $stable(neg_q_o)));
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt_q < CNT_W'(LAT_FULL)));

endmodule

// File: rtl/mul_accum.sv
`timescale 1ns/1ps
module mul_accum #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CHUNK_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                step_i,
  input  logic [DATA_W-1:0]   mag_a_i,
  input  logic [DATA_W-1:0]   mag_b_i,
  output logic [2*DATA_W-1:0] acc_o
);

  localparam int unsigned PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] mcand_q;
  logic [DATA_W-1:0] mplier_q;
  logic [PROD_W-1:0] acc_q;

  function automatic logic [PROD_W-1:0] partial(
    input logic [PROD_W-1:0] mc, input logic [CHUNK_W-1:0] slice);
    logic [PROD_W-1:0] wide;
    wide = {{(PROD_W-CHUNK_W){1'b0}}, slice};
    return mc * wide;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else if (load_i) begin
      mcand_q  <= {{DATA_W{1'b0}}, mag_a_i};
      mplier_q <= mag_b_i;
      acc_q    <= '0;
    end else if (step_i) begin
      acc_q    <= acc_q + partial(mcand_q, mplier_q[CHUNK_W-1:0]);
      mcand_q  <= mcand_q << CHUNK_W;
      mplier_q <= mplier_q >> CHUNK_W;
    end
  end

  assign acc_o = acc_q;

  assert_acc_no_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (acc_o >= $past(acc_o)));

endmodule

// File: rtl/mul_finalize.sv
`timescale 1ns/1ps
module mul_finalize
  import mul_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fin_i,
  input  logic [1:0]          op_i,
  input  logic                neg_i,
  input  logic [2*DATA_W-1:0] acc_i,
  output logic                done_o,
  output logic [DATA_W-1:0]   hi_o,
  output logic [DATA_W-1:0]   lo_o,
  output logic                n_o,
  output logic                z_o,
  output logic                v_o,
  output logic                upd_n_o,
  output logic                upd_z_o,
  output logic                upd_v_o
);

  localparam int unsigned PROD_W = 2 * DATA_W;

  function automatic logic [PROD_W-1:0] apply_sign(
    input logic [PROD_W-1:0] mag, input logic neg);
    if (neg) return ~mag + 1'b1;
    return mag;
  endfunction

  function automatic logic overflows(
    input logic [PROD_W-1:0] p, input logic sgn);
    if (sgn) return p[PROD_W-1:DATA_W] != {DATA_W{p[DATA_W-1]}};
    return |p[PROD_W-1:DATA_W];
  endfunction

  logic [PROD_W-1:0] prod_w;
  logic              half_w;
  logic [DATA_W-1:0] lo_q, hi_q;
  logic              n_q, z_q, v_q, done_q, un_q, uz_q, uv_q;

  always_comb begin
    prod_w = apply_sign(acc_i, neg_i);
    half_w = op_is_half(op_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      n_q    <= 1'b0;
      z_q    <= 1'b0;
      v_q    <= 1'b0;
      done_q <= 1'b0;
      un_q   <= 1'b0;
      uz_q   <= 1'b0;
      uv_q   <= 1'b0;
    end else begin
      done_q <= fin_i;
      un_q   <= fin_i;
      uz_q   <= fin_i;
      uv_q   <= fin_i & ~half_w;
      if (fin_i) begin
        lo_q <= prod_w[DATA_W-1:0];
        n_q  <= prod_w[DATA_W-1];
        z_q  <= (prod_w[DATA_W-1:0] == '0);
        if (!half_w) begin
          hi_q <= prod_w[PROD_W-1:DATA_W];
          v_q  <= overflows(prod_w, op_is_signed(op_i));
        end
      end
    end
  end

  assign done_o  = done_q;
  assign hi_o    = hi_q;
  assign lo_o    = lo_q;
  assign n_o     = n_q;
  assign z_o     = z_q;
  assign v_o     = v_q;
  assign upd_n_o = un_q;
  assign upd_z_o = uz_q;
  assign upd_v_o = uv_q;

  assert_hi_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_i && half_w) |=> $stable(hi_o));
  assert_v_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_i && half_w) |=> ($stable(v_o) && !upd_v_o));
  assert_regs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_i |=> ($stable(hi_o) && $stable(lo_o) && $stable(n_o) && $stable(z_o) && $stable(v_o)));
  assert_strobe_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_n_o || upd_z_o || upd_v_o) |-> done_o);
  assert_zero_tracks_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((z_o == (lo_o == '0)) && (n_o == lo_o[DATA_W-1])));

endmodule

// File: rtl/mul_seq_unit.sv
`timescale 1ns/1ps
module mul_seq_unit #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned HALF_W  = 16,
  parameter int unsigned CHUNK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_v_o,
  output logic              upd_n_o,
  output logic              upd_z_o,
  output logic              upd_v_o
);

  logic [DATA_W-1:0]   mag_a_w, mag_b_w;
  logic                neg_w, neg_q_w;
  logic                load_w, step_w, fin_w;
  logic [1:0]          op_q_w;
  logic [2*DATA_W-1:0] acc_w;

  mul_operand_prep #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_prep (
    .op_i    (op_i),
    .a_i     (opa_i),
    .b_i     (opb_i),
    .mag_a_o (mag_a_w),
    .mag_b_o (mag_b_w),
    .neg_o   (neg_w)
  );

  mul_ctrl #(.DATA_W(DATA_W), .HALF_W(HALF_W), .CHUNK_W(CHUNK_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .op_i    (op_i),
    .neg_i   (neg_w),
    .load_o  (load_w),
    .step_o  (step_w),
    .fin_o   (fin_w),
    .busy_o  (busy_o),
    .op_q_o  (op_q_w),
    .neg_q_o (neg_q_w)
  );

  mul_accum #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_w),
    .step_i  (step_w),
    .mag_a_i (mag_a_w),
    .mag_b_i (mag_b_w),
    .acc_o   (acc_w)
  );

  mul_finalize #(.DATA_W(DATA_W)) u_fin (
    .clk     (clk),
    .rst_n   (rst_n),
    .fin_i   (fin_w),
    .op_i    (op_q_w),
    .neg_i   (neg_q_w),
    .acc_i   (acc_w),
    .done_o  (done_o),
    .hi_o    (hi_o),
    .lo_o    (lo_o),
    .n_o     (flag_n_o),
    .z_o     (flag_z_o),
    .v_o     (flag_v_o),
    .upd_n_o (upd_n_o),
    .upd_z_o (upd_z_o),
    .upd_v_o (upd_v_o)
  );

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

// File: tb/mul_seq_unit_test.sv
`timescale 1ns/1ps
module mul_seq_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] a = '0, b = '0;
  logic        busy, done, fn, fz, fv, un, uz, uv;
  logic [31:0] hi, lo;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] hi_m = '0, lo_m = '0;
  logic        n_m = 1'b0, z_m = 1'b0, v_m = 1'b0;

  always #4 clk = ~clk;

  mul_seq_unit uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .opa_i(a), .opb_i(b),
    .busy_o(busy), .done_o(done), .hi_o(hi), .lo_o(lo),
    .flag_n_o(fn), .flag_z_o(fz), .flag_v_o(fv),
    .upd_n_o(un), .upd_z_o(uz), .upd_v_o(uv)
  );

  // op, operand a, operand b
  localparam int NVEC = 14;
  localparam logic [65:0] VEC [NVEC] = '{
    {2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {2'b10, 32'h0000_FFFF, 32'h0001_FFFF},
    {2'b00, 32'h8000_0000, 32'h8000_0000},
    {2'b11, 32'h1234_FFFF, 32'hABCD_FFFF},
    {2'b00, 32'h8000_0000, 32'hFFFF_FFFF},
    {2'b10, 32'h0000_8000, 32'h0000_8000},
    {2'b00, 32'h8000_0000, 32'h0000_0001},
    {2'b10, 32'h0000_8000, 32'h0000_0001},
    {2'b01, 32'h0000_0001, 32'h8000_0000},
    {2'b00, 32'h0000_0000, 32'h1234_5678},
    {2'b11, 32'hFFFF_0000, 32'h0000_0005},
    {2'b01, 32'h1234_5678, 32'h9ABC_DEF0},
    {2'b00, 32'h7FFF_FFFF, 32'h0000_0001}
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_prod(input logic [1:0] o,
                                           input logic [31:0] x, input logic [31:0] y);
    logic signed [63:0] sx, sy;
    case (o)
      2'b00: begin sx = $signed(x); sy = $signed(y); return sx * sy; end
      2'b01: return {32'b0, x} * {32'b0, y};
      2'b10: begin
        sx = $signed(x[15:0]); sy = $signed(y[15:0]);
        return {32'b0, 32'(sx * sy)};
      end
      default: return {48'b0, x[15:0]} * {48'b0, y[15:0]};
    endcase
  endfunction

  task automatic run_op(input logic [1:0] o, input logic [31:0] x,
                        input logic [31:0] y, input bit poke);
    logic [63:0] p;
    int lat;
    string tl;
    p   = ref_prod(o, x, y);
    lat = o[1] ? 3 : 5;
    tl  = o[1] ? "R4" : "R3";
    if (o[1]) lo_m = p[31:0];
    else begin
      {hi_m, lo_m} = p;
      v_m = o[0] ? (p[63:32] != 0) : (p[63:32] != {32{p[31]}});
    end
    n_m = lo_m[31];
    z_m = (lo_m == 0);
    op = o; a = x; b = y; start = 1'b1;
    for (int j = 1; j <= lat; j++) begin
      @(negedge clk);
      if (j == 1) start = 1'b0;
      if (poke && j == 2) begin start = 1'b1; op = ~o; a = ~x; b = y + 1; end
      if (poke && j == 3) start = 1'b0;
      check(tl, "busy/done while running", {busy, done}, 2'b10);
    end
    @(negedge clk);
    start = 1'b0;
    check(tl, "busy/done at completion", {busy, done}, 2'b01);
    check(o[1] ? "R2" : "R1", "hi", hi, hi_m);
    check(o[1] ? "R2" : "R1", "lo", lo, lo_m);
    check("R6", "n,z", {fn, fz}, {n_m, z_m});
    check("R6", "upd n,z", {un, uz}, 2'b11);
    check(o[1] ? "R8" : "R7", "v", fv, v_m);
    check("R7", "upd v", uv, !o[1]);
    if (poke) begin
      @(negedge clk);
      check("R5", "no second operation", {busy, done}, 2'b00);
      check("R10", "result held", {hi, lo}, {hi_m, lo_m});
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "reset outputs", {busy, done, un, uz, uv, fn, fz, fv},
          8'h00);
    check("R9", "reset results", {hi, lo}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "idle after reset", {busy, done}, 2'b00);

    for (int i = 0; i < NVEC; i++)
      run_op(VEC[i][65:64], VEC[i][63:32], VEC[i][31:0], 1'b0);

    // start pulses during busy, both widths
    run_op(2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
    run_op(2'b10, 32'h0000_8000, 32'h0000_7FFF, 1'b1);

    // idle gap: nothing moves without a start (R10)
    repeat (4) @(negedge clk);
    check("R10", "idle hold", {hi, lo, fn, fz, fv, done}, {hi_m, lo_m, n_m, z_m, v_m, 1'b0});

    for (int i = 0; i < 60; i++) begin
      logic [1:0]  ro;
      logic [31:0] ra, rb;
      ro = 2'($urandom_range(0, 3));
      ra = $urandom();
      rb = $urandom();
      if (i % 5 == 0) ra = 32'h8000_0000;
      if (i % 6 == 0) rb = 32'hFFFF_FFFF;
      run_op(ro, ra, rb, (i % 7) == 3);
    end

    summary();
    $finish;
  end

endmodule